// File: doc/BRIEF.md
# 64-bit Timebase with Coherent Word Access

The block keeps a 64-bit count of elapsed time since reset. It is reached through a word-wide register bus with an address, a write enable, write data, a read enable and read data. Software reaches the 64-bit count 32 bits at a time. A read of the low word copies the high word into a latch, so a following read of the latched high word belongs to the same instant. A write of the low word only stages it. A write of the high word loads both halves at once.

The count advances either on an external single-cycle tick pulse or on every clock, chosen by a source bit. A software pause bit stops it. Each of the debug-halt inputs also stops it while that input's enable bit is set. Two raw words return the live count without touching the latch. A lock bit, once set, blocks every further bus write until reset.

Top module: `timebase64`

## Requirements
- R1: After reset the count is 0, the high-word latch is 0, the source bit is 0, the pause bit is 0, both debug-halt enable bits are 1 and the lock is clear. The control word then reads 0xC.
- R2: A read at word 0 returns count bits 31:0 and, at the same edge, copies count bits 63:32 into the latch. A read at word 1 returns the latch.
- R3: A write at word 2 stages the low half and leaves the count unchanged. A write at word 3 loads the count with {write data, staged low half}.
- R4: Reads at word 4 and word 5 return live count bits 31:0 and 63:32, and they leave the latch unchanged.
- R5: The control word is word 6, and its bit 0 is the source. With source 0, the count gains one on each clock where tick is high. With source 1, it gains exactly one on every clock whatever tick is.
- R6: While control bit 1 (pause) is set, the count holds.
- R7: Control bit 2+i enables debug port i. While it is set and dbg_halt[i] is high, the count holds. A halt on a port whose enable bit is clear has no effect.
- R8: Writing 1 to bit 0 of word 7 sets the lock. While it is set, every bus write is ignored, including writes to word 7. Only reset clears it. Word 7 reads the lock in bit 0.
- R9: rd_data takes the addressed value at the clock edge where rd_en is high, and it holds that value until the next read. Words 2 and 3 read as 0.
- R10: A load from a word-3 write takes priority over an increment in the same cycle. The count becomes exactly the written value.
- R11: An increment carries from bit 31 into bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle time step pulse |
| dbg_halt | input | DBG_N | Debug-halt request per debug port |
| addr | input | 3 | Word address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WORD_W | Registered read data |

## Verification
The count is driven by tick pulses alone with the source bit at 0. Counts are then compared exactly, including a carry across bit 31 and a load made in the same cycle as a tick. In clock mode, two back-to-back raw reads must differ by exactly one even with tick held high; this separates the two sources. The same paired reads are repeated with pause set and with each debug-halt input raised while its enable bit is set and while it is clear, which shows which stop conditions actually stop the count. The latch is checked by advancing the count between the low read and the high read, and by placing a raw read between them.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        W_LO_SNAP = 3'd0,
        W_HI_HELD = 3'd1,
        W_LO_STAGE = 3'd2,
        W_HI_LOAD = 3'd3,
        W_LO_LIVE = 3'd4,
        W_HI_LIVE = 3'd5,
        W_CONTROL = 3'd6,
        W_LOCK = 3'd7
    } word_sel_e;

    localparam int CTL_SRC_BIT = 0;
    localparam int CTL_PAUSE_BIT = 1;
    localparam int CTL_DBG_LSB = 2;
    localparam int LOCK_BIT = 0;

endpackage

// File: rtl/timebase_step.sv
module timebase_step #(
    parameter int DBG_N = 2
) (
    input  logic             tick,
    input  logic             src_clk,
    input  logic             pause,
    input  logic [DBG_N-1:0] dbg_en,
    input  logic [DBG_N-1:0] dbg_halt,
    output logic             advance
);
    logic [DBG_N-1:0] halt_hit;
    logic             step_src;

    genvar gi;
    generate
        for (gi = 0; gi < DBG_N; gi++) begin : g_port
            assign halt_hit[gi] = dbg_en[gi] & dbg_halt[gi];
        end
    endgenerate

    always_comb begin
        step_src = src_clk ? 1'b1 : tick;
        advance  = step_src & ~pause & ~(|halt_hit);
    end
endmodule

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
    import timebase_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DBG_N  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              src_clk,
    output logic              pause,
    output logic [DBG_N-1:0]  dbg_en,
    output logic              locked,
    output logic [WORD_W-1:0] stage_lo,
    output logic              commit
);
    typedef struct packed {
        logic              src;
        logic              pause;
        logic [DBG_N-1:0]  dbg_en;
        logic              lock;
        logic [WORD_W-1:0] stage;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       wr_ok;

    always_comb begin
        st_d   = st_q;
        wr_ok  = wr_en & ~st_q.lock;
        commit = 1'b0;
        if (wr_ok) begin
            case (addr)
                W_LO_STAGE: st_d.stage = wr_data;
                W_HI_LOAD:  commit = 1'b1;
                W_CONTROL: begin
                    st_d.src    = wr_data[CTL_SRC_BIT];
                    st_d.pause  = wr_data[CTL_PAUSE_BIT];
                    st_d.dbg_en = wr_data[CTL_DBG_LSB +: DBG_N];
                end
                W_LOCK: begin
                    if (wr_data[LOCK_BIT]) st_d.lock = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.src    <= 1'b0;
            st_q.pause  <= 1'b0;
            st_q.dbg_en <= '1;
            st_q.lock   <= 1'b0;
            st_q.stage  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_clk  = st_q.src;
    assign pause    = st_q.pause;
    assign dbg_en   = st_q.dbg_en;
    assign locked   = st_q.lock;
    assign stage_lo = st_q.stage;
endmodule

// File: rtl/timebase_core.sv
module timebase_core #(
    parameter int WORD_W = 32,
    localparam int TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              commit,
    input  logic [TIME_W-1:0] commit_val,
    input  logic              snap_req,
    output logic [TIME_W-1:0] count,
    output logic [WORD_W-1:0] hi_latch
);
    typedef struct packed {
        logic [TIME_W-1:0] cnt;
        logic [WORD_W-1:0] held;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.cnt = commit_val;
        end else if (advance) begin
            st_d.cnt = st_q.cnt + TIME_W'(1);
        end
        if (snap_req) begin
            st_d.held = st_q.cnt[TIME_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign hi_latch = st_q.held;
endmodule

// File: rtl/timebase64.sv
module timebase64
    import timebase_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DBG_N  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DBG_N-1:0]  dbg_halt,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data
);
    localparam int TIME_W = 2 * WORD_W;
    localparam int CTL_W  = CTL_DBG_LSB + DBG_N;

    logic              src_clk;
    logic              pause;
    logic [DBG_N-1:0]  dbg_en;
    logic              locked;
    logic [WORD_W-1:0] stage_lo;
    logic              commit;
    logic              advance;
    logic              snap_req;
    logic [TIME_W-1:0] count;
    logic [WORD_W-1:0] hi_latch;
    logic [CTL_W-1:0]  ctl_word;

    logic [WORD_W-1:0] rd_d, rd_q;

    timebase_ctrl #(.WORD_W(WORD_W), .DBG_N(DBG_N)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .src_clk(src_clk), .pause(pause), .dbg_en(dbg_en), .locked(locked),
        .stage_lo(stage_lo), .commit(commit)
    );

    timebase_step #(.DBG_N(DBG_N)) u_step (
        .tick(tick), .src_clk(src_clk), .pause(pause), .dbg_en(dbg_en),
        .dbg_halt(dbg_halt), .advance(advance)
    );

    timebase_core #(.WORD_W(WORD_W)) u_core (
        .clk(clk), .rst(rst), .advance(advance), .commit(commit),
        .commit_val({wr_data, stage_lo}), .snap_req(snap_req),
        .count(count), .hi_latch(hi_latch)
    );

    always_comb begin
        snap_req = rd_en && (addr == W_LO_SNAP);
        ctl_word = '0;
        ctl_word[CTL_SRC_BIT] = src_clk;
        ctl_word[CTL_PAUSE_BIT] = pause;
        ctl_word[CTL_DBG_LSB +: DBG_N] = dbg_en;
        rd_d = rd_q;
        if (rd_en) begin
            case (addr)
                W_LO_SNAP: rd_d = count[WORD_W-1:0];
                W_HI_HELD: rd_d = hi_latch;
                W_LO_LIVE: rd_d = count[WORD_W-1:0];
                W_HI_LIVE: rd_d = count[TIME_W-1:WORD_W];
                W_CONTROL: rd_d = WORD_W'(ctl_word);
                W_LOCK:    rd_d = WORD_W'(locked);
                default:   rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/timebase64_chk.sv
module timebase64_chk
    import timebase_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DBG_N  = 2,
    localparam int TIME_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        addr,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DBG_N-1:0]  dbg_halt,
    input logic [TIME_W-1:0] count,
    input logic [WORD_W-1:0] hi_latch,
    input logic [WORD_W-1:0] stage_lo,
    input logic              locked,
    input logic              src_clk,
    input logic              pause,
    input logic [DBG_N-1:0]  dbg_en
);
    logic load_now;
    logic halted;
    assign load_now = wr_en && !locked && (addr == W_HI_LOAD);
    assign halted   = |(dbg_en & dbg_halt);

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R8
    locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en) |=> ($stable(stage_lo) && $stable(src_clk)
                               && $stable(pause) && $stable(dbg_en)));

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pause && !load_now) |=> (count == $past(count)));

    // R7
    dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !load_now) |=> (count == $past(count)));

    // R5
    clock_step_chk: assert property (@(posedge clk) disable iff (rst)
        (src_clk && !pause && !halted && !load_now)
        |=> (count == $past(count) + TIME_W'(1)));

    // R10
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load_now |=> (count == {$past(wr_data), $past(stage_lo)}));

    // R4
    raw_keeps_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == W_LO_LIVE || addr == W_HI_LIVE)) |=> $stable(hi_latch));

    // R2
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == W_LO_SNAP) |=> (hi_latch == $past(count[TIME_W-1:WORD_W])));
endmodule

bind timebase64 timebase64_chk #(.WORD_W(WORD_W), .DBG_N(DBG_N)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .dbg_halt(dbg_halt), .count(count), .hi_latch(hi_latch),
    .stage_lo(stage_lo), .locked(locked), .src_clk(src_clk), .pause(pause),
    .dbg_en(dbg_en)
);

// File: tb/timebase64_bench.sv
module timebase64_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 32;
    localparam int DBG_N = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic [DBG_N-1:0]  dbg_halt = '0;
    logic [2:0]        addr = '0;
    logic              wr_en = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [WORD_W-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    timebase64 #(.WORD_W(WORD_W), .DBG_N(DBG_N)) u_timebase64 (
        .clk(clk), .rst(rst), .tick(tick), .dbg_halt(dbg_halt), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // every bus task starts and ends just after a falling edge
    task automatic bus_wr(input logic [2:0] a, input logic [WORD_W-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [WORD_W-1:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        d = rd_data; rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [WORD_W-1:0] v;
        bus_rd(3'd6, v); check("R1 control", v, 32'hC);
        bus_rd(3'd4, v); check("R1 raw lo", v, 32'h0);
        bus_rd(3'd5, v); check("R1 raw hi", v, 32'h0);
        bus_rd(3'd1, v); check("R1 latch", v, 32'h0);
        bus_rd(3'd7, v); check("R1 lock", v, 32'h0);
    endtask

    task automatic t_staged_write();
        logic [WORD_W-1:0] v;
        bus_wr(3'd2, 32'hFFFF_FFFE);
        bus_rd(3'd4, v); check("R3 stage only", v, 32'h0);
        bus_rd(3'd2, v); check("R9 stage word reads 0", v, 32'h0);
        tick = 1'b1;                 // R10: load and tick in same cycle
        bus_wr(3'd3, 32'h0000_0005);
        tick = 1'b0;
        bus_rd(3'd4, v); check("R10 lo exact", v, 32'hFFFF_FFFE);
        bus_rd(3'd5, v); check("R3 hi loaded", v, 32'h5);
    endtask

    task automatic t_tick_count();
        logic [WORD_W-1:0] v;
        bus_rd(3'd4, v); check("R5 no tick no step", v, 32'hFFFF_FFFE);
        pulse_tick(); pulse_tick(); pulse_tick();
        bus_rd(3'd4, v); check("R11 lo after carry", v, 32'h1);
        pulse_tick();
        check("R9 rd_data held", rd_data, 32'h1);
        bus_rd(3'd5, v); check("R11 hi after carry", v, 32'h6);
    endtask

    task automatic t_latch();
        logic [WORD_W-1:0] v;
        bus_wr(3'd2, 32'hFFFF_FFFF);
        bus_wr(3'd3, 32'h7);
        bus_rd(3'd0, v); check("R2 lo read", v, 32'hFFFF_FFFF);
        pulse_tick();
        bus_rd(3'd5, v); check("R4 raw hi live", v, 32'h8);
        bus_rd(3'd1, v); check("R2 latched hi", v, 32'h7);
        bus_rd(3'd4, v); check("R4 raw lo live", v, 32'h0);
        bus_rd(3'd1, v); check("R4 latch kept", v, 32'h7);
        bus_rd(3'd0, v); check("R2 lo reread", v, 32'h0);
        bus_rd(3'd1, v); check("R2 new latch", v, 32'h8);
    endtask

    task automatic t_clock_source();
        logic [WORD_W-1:0] a, b;
        bus_wr(3'd6, 32'hD);
        bus_wr(3'd2, 32'h100);
        bus_wr(3'd3, 32'h2);
        bus_rd(3'd4, a); check("R10 clock-mode load", a, 32'h100);
        bus_rd(3'd4, b); check("R5 one per clock", b, 32'h101);
        tick = 1'b1;
        bus_rd(3'd4, a);
        bus_rd(3'd4, b);
        tick = 1'b0;
        check("R5 tick ignored", b - a, 32'h1);
    endtask

    task automatic t_pause();
        logic [WORD_W-1:0] a, b;
        bus_wr(3'd6, 32'hF);
        bus_rd(3'd4, a);
        bus_rd(3'd4, b);
        check("R6 paused hold", b, a);
        bus_rd(3'd6, a); check("R6 control readback", a, 32'hF);
    endtask

    task automatic t_debug_halt();
        logic [WORD_W-1:0] a, b;
        bus_wr(3'd6, 32'hD);
        dbg_halt = 2'b10;
        bus_rd(3'd4, a); bus_rd(3'd4, b);
        check("R7 port1 hold", b, a);
        bus_wr(3'd6, 32'h5);
        bus_rd(3'd4, a); bus_rd(3'd4, b);
        check("R7 port1 disabled", b - a, 32'h1);
        dbg_halt = 2'b01;
        bus_rd(3'd4, a); bus_rd(3'd4, b);
        check("R7 port0 hold", b, a);
        dbg_halt = 2'b00;
        bus_rd(3'd4, a); bus_rd(3'd4, b);
        check("R7 released", b - a, 32'h1);
    endtask

    task automatic t_lock();
        logic [WORD_W-1:0] v;
        bus_wr(3'd6, 32'h0);
        bus_wr(3'd2, 32'h55);
        bus_wr(3'd3, 32'h66);
        bus_wr(3'd7, 32'h1);
        bus_rd(3'd7, v); check("R8 lock set", v, 32'h1);
        bus_wr(3'd6, 32'h1);
        bus_wr(3'd2, 32'h11);
        bus_wr(3'd3, 32'h22);
        bus_wr(3'd7, 32'h0);
        bus_rd(3'd6, v); check("R8 control frozen", v, 32'h0);
        bus_rd(3'd7, v); check("R8 lock sticky", v, 32'h1);
        bus_rd(3'd4, v); check("R8 lo not loaded", v, 32'h55);
        bus_rd(3'd5, v); check("R8 hi not loaded", v, 32'h66);
        do_reset();
        bus_rd(3'd7, v); check("R8 reset clears lock", v, 32'h0);
        bus_rd(3'd6, v); check("R1 control after reset", v, 32'hC);
        bus_rd(3'd4, v); check("R1 count after reset", v, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_staged_write();
        t_tick_count();
        t_latch();
        t_clock_source();
        t_pause();
        t_debug_halt();
        t_lock();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule